// File: doc/BRIEF.md
# Video Test Pattern Generator with Loopback Self-Test

This block produces full-field component video test rasters as a stream of 10-bit words and checks that the same stream comes back unchanged after travelling through the datapath under test. A 4-bit code on the low bits of a 10-bit code word picks one of four patterns: flat black, a PLL stress pattern, an equalizer stress pattern, or eight vertical colour bars at 75% amplitude. A two-bit format picks either the 525-line or the 625-line family, and either the standard or the wide raster. Every line starts with an end-of-video timing word group and ends its blanking with a start-of-video group. Each group carries field, vertical-blanking and horizontal flags and their protection bits.

The test is started by raising an enable. That enable is normally tied to the PLL lock indicator. The code and the format are captured on the rising edge of the enable, and the raster then starts from line 0, sample 0. Every returned word is compared with the word that was sent a fixed number of cycles earlier. If two complete fields come back with no mismatch, the pass output goes high. A single mismatch holds pass low until the enable is dropped, which also stops the stream.

The line length, the frame height, the horizontal blanking width and the vertical blanking depth are parameters. They can be set to full standard values or kept small for fast simulation.

Top module: `vtpg_bist`

## Requirements
- R1: While rst_ni is low, tx_valid_o, tx_word_o and pass_o are all zero.
- R2: At the first clock edge where tpg_en_i is sampled high, code_i and fmt_i are captured. fmt_i[0]=1 selects the 625-line family and fmt_i[1]=1 selects the wide raster. tx_valid_o rises one edge later, and the first word, line 0 sample 0, is 3FFh. Changes to code_i or fmt_i while the enable stays high have no effect on the stream.
- R3: Each line is T words long, where T is set per format. Words 0..3 are 3FFh, 000h, 000h, XYZ. Words B-4..B-1 have the same form, where B is the blanking length. XYZ = {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}. H=1 at word 0 and H=0 at word B-4. F=0 in the first half of the frame lines. V=1 in the first VBL lines of each field.
- R4: Every other blanking word is 200h at an even sample index and 040h at an odd one. This covers horizontal blanking and the whole active region of vertical blanking lines.
- R5: Let a = sample - B. In active lines the component order by a mod 4 is Cb, Y, Cr, Y. Code 1 (black) gives chroma 200h and luma 040h. Code 2 (PLL stress) gives 200h and 110h. Code 3 (EQ stress) gives 300h and 198h in the upper half of the field's lines, and 200h and 110h in the lower half.
- R6: Code 4 gives eight bars, each (T-B)/8 samples wide, with values switching abruptly at the bar edges. The bars, left to right, as Y/Cb/Cr, are: 2D0/200/200, 288/0B0/238, 20C/270/0B0, 1C0/120/0E8, 150/2E0/318, 104/190/350, 08C/350/1C8, 040/200/200.
- R7: Any code word with bits 9:4 not zero, or with a low nibble outside 1..4, keeps tx_valid_o low and pass_o low for as long as the enable stays high.
- R8: rx_word_i is compared with tx_word_o as it was LAT cycles earlier. If every compared word matches, pass_o rises at edge 2·FW+1+LAT after the start edge, where FW is the number of words in one field.
- R9: Any mismatch holds pass_o low until the enable drops. If pass_o is already high, a mismatch takes it low at the next edge.
- R10: One edge after tpg_en_i is sampled low, pass_o and tx_valid_o are low and the error record is cleared. A new enable restarts from line 0, sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tpg_en_i | input | 1 | Test enable (start on rise, stop on fall) |
| code_i | input | 10 | Pattern code word, low nibble significant |
| fmt_i | input | 2 | bit0 = 625-line family, bit1 = wide raster |
| rx_word_i | input | 10 | Word returned from the datapath under test |
| tx_word_o | output | 10 | Generated video word |
| tx_valid_o | output | 1 | Generated word is valid |
| pass_o | output | 1 | Two error-free fields completed |

## Verification
Counting field completions and detecting a mismatch can happen in the same compare cycle. This is the case when the returned copy of the last word of the second field is corrupt. The bench provokes it by flipping one bit of rx_word_i in exactly that cycle, and it expects pass_o never to rise during that run. A second case corrupts a word a few cycles after pass_o has risen, and pass_o must fall on the next edge. Fault positions are also drawn at random from across both fields.

// File: rtl/vtpg_pkg.sv
`timescale 1ns/1ps
package vtpg_pkg;
  localparam int WORD_W = 10;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {PAT_NONE, PAT_BLACK, PAT_PLL, PAT_EQ, PAT_BARS} pat_e;

  function automatic pat_e code_to_pat(input word_t c);
    if (c[WORD_W-1:4] != '0) return PAT_NONE;
    case (c[3:0])
      4'd1:    return PAT_BLACK;
      4'd2:    return PAT_PLL;
      4'd3:    return PAT_EQ;
      4'd4:    return PAT_BARS;
      default: return PAT_NONE;
    endcase
  endfunction

  function automatic word_t trs_xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  // sel: 0 Cb, 1 Y, 2 Cr, 3 Y
  function automatic word_t bar_word(input logic [2:0] idx, input logic [1:0] sel);
    logic [29:0] ycc;
    case (idx)
      3'd0: ycc = {10'h2D0, 10'h200, 10'h200};
      3'd1: ycc = {10'h288, 10'h0B0, 10'h238};
      3'd2: ycc = {10'h20C, 10'h270, 10'h0B0};
      3'd3: ycc = {10'h1C0, 10'h120, 10'h0E8};
      3'd4: ycc = {10'h150, 10'h2E0, 10'h318};
      3'd5: ycc = {10'h104, 10'h190, 10'h350};
      3'd6: ycc = {10'h08C, 10'h350, 10'h1C8};
      default: ycc = {10'h040, 10'h200, 10'h200};
    endcase
    case (sel)
      2'd0:    return ycc[19:10];
      2'd2:    return ycc[9:0];
      default: return ycc[29:20];
    endcase
  endfunction
endpackage

// File: rtl/vtpg_raster.sv
`timescale 1ns/1ps
module vtpg_raster #(
  parameter int SMP_N43  = 64,
  parameter int SMP_N169 = 80,
  parameter int SMP_P43  = 72,
  parameter int SMP_P169 = 96,
  parameter int LINES_N  = 10,
  parameter int LINES_P  = 12,
  parameter int BLANK    = 16,
  parameter int VBL      = 1,
  localparam int SMP_MAXA = (SMP_N43 > SMP_N169) ? SMP_N43 : SMP_N169,
  localparam int SMP_MAXB = (SMP_P43 > SMP_P169) ? SMP_P43 : SMP_P169,
  localparam int SMP_MAX  = (SMP_MAXA > SMP_MAXB) ? SMP_MAXA : SMP_MAXB,
  localparam int LIN_MAX  = (LINES_N > LINES_P) ? LINES_N : LINES_P,
  localparam int SW = $clog2(SMP_MAX + 1),
  localparam int LW = $clog2(LIN_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          pal_i,
  input  logic          wide_i,
  output logic [SW-1:0] smp_o,
  output logic          fld_o,
  output logic          vbl_o,
  output logic          upper_o,
  output logic [2:0]    bar_o,
  output logic          fend_o
);
  logic [SW-1:0] smp_q, bcnt_q, tot_w, bw_w;
  logic [LW-1:0] line_q, lines_w, half_w, lif_w;
  logic [2:0]    bar_q;
  logic          last_smp;

  assign tot_w   = pal_i ? (wide_i ? SW'(SMP_P169) : SW'(SMP_P43))
                         : (wide_i ? SW'(SMP_N169) : SW'(SMP_N43));
  assign lines_w = pal_i ? LW'(LINES_P) : LW'(LINES_N);
  assign half_w  = lines_w >> 1;
  assign bw_w    = (tot_w - SW'(BLANK)) >> 3;
  assign last_smp = (smp_q == tot_w - SW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      line_q <= '0;
      bar_q  <= '0;
      bcnt_q <= '0;
    end else if (!run_i) begin
      smp_q  <= '0;
      line_q <= '0;
      bar_q  <= '0;
      bcnt_q <= '0;
    end else begin
      smp_q <= last_smp ? '0 : smp_q + SW'(1);
      if (last_smp) line_q <= (line_q == lines_w - LW'(1)) ? '0 : line_q + LW'(1);
      if (smp_q == SW'(BLANK - 1)) begin
        bar_q  <= '0;
        bcnt_q <= '0;
      end else if (smp_q >= SW'(BLANK)) begin
        if (bcnt_q == bw_w - SW'(1)) begin
          bcnt_q <= '0;
          if (bar_q != 3'd7) bar_q <= bar_q + 3'd1;
        end else begin
          bcnt_q <= bcnt_q + SW'(1);
        end
      end
    end
  end

  assign fld_o   = (line_q >= half_w);
  assign lif_w   = fld_o ? line_q - half_w : line_q;
  assign vbl_o   = (lif_w < LW'(VBL));
  assign upper_o = (lif_w < (half_w >> 1));
  assign smp_o   = smp_q;
  assign bar_o   = bar_q;
  assign fend_o  = last_smp && ((line_q == half_w - LW'(1)) || (line_q == lines_w - LW'(1)));
endmodule

// File: rtl/vtpg_pattern.sv
`timescale 1ns/1ps
module vtpg_pattern
  import vtpg_pkg::*;
#(
  parameter int BLANK = 16,
  parameter int SW    = 7
) (
  input  pat_e          pat_i,
  input  logic [SW-1:0] smp_i,
  input  logic          fld_i,
  input  logic          vbl_i,
  input  logic          upper_i,
  input  logic [2:0]    bar_i,
  output word_t         word_o
);
  logic [SW-1:0] act_w;
  logic [1:0]    sel_w;
  logic          luma_w;

  assign act_w  = smp_i - SW'(BLANK);
  assign sel_w  = act_w[1:0];
  assign luma_w = act_w[0];

  always_comb begin
    if (smp_i < SW'(4) || (smp_i >= SW'(BLANK - 4) && smp_i < SW'(BLANK))) begin
      // BLANK is a multiple of 4, so smp_i[1:0] is the position within the group
      case (smp_i[1:0])
        2'd0:    word_o = 10'h3FF;
        2'd3:    word_o = trs_xyz(fld_i, vbl_i, smp_i < SW'(4));
        default: word_o = 10'h000;
      endcase
    end else if (smp_i < SW'(BLANK) || vbl_i) begin
      word_o = smp_i[0] ? 10'h040 : 10'h200;
    end else begin
      case (pat_i)
        PAT_PLL:  word_o = luma_w ? 10'h110 : 10'h200;
        PAT_EQ:   word_o = upper_i ? (luma_w ? 10'h198 : 10'h300)
                                   : (luma_w ? 10'h110 : 10'h200);
        PAT_BARS: word_o = bar_word(bar_i, sel_w);
        default:  word_o = luma_w ? 10'h040 : 10'h200;
      endcase
    end
  end
endmodule

// File: rtl/vtpg_checker.sv
`timescale 1ns/1ps
module vtpg_checker
  import vtpg_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  word_t tx_word_i,
  input  logic  tx_valid_i,
  input  logic  tx_fend_i,
  input  word_t rx_word_i,
  output logic  pass_o,
  output logic  err_o
);
  word_t exp_d  [LAT];
  logic  vld_d  [LAT];
  logic  fend_d [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    word_t src_w;
    logic  src_v, src_f;
    if (g == 0) begin : g_head
      assign src_w = tx_word_i;
      assign src_v = tx_valid_i;
      assign src_f = tx_fend_i;
    end else begin : g_tail
      assign src_w = exp_d[g-1];
      assign src_v = vld_d[g-1];
      assign src_f = fend_d[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exp_d[g]  <= '0;
        vld_d[g]  <= 1'b0;
        fend_d[g] <= 1'b0;
      end else begin
        exp_d[g]  <= src_w;
        vld_d[g]  <= en_i && src_v;
        fend_d[g] <= en_i && src_f;
      end
    end
  end

  logic [1:0] fcnt_q, fcnt_n;
  logic       err_q, err_n, pass_q, pass_n, hit_w;

  assign hit_w  = vld_d[LAT-1];
  assign err_n  = err_q || (hit_w && (exp_d[LAT-1] != rx_word_i));
  assign fcnt_n = (hit_w && fend_d[LAT-1] && fcnt_q != 2'd2) ? fcnt_q + 2'd1 : fcnt_q;
  assign pass_n = (fcnt_n == 2'd2) && !err_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      err_q  <= 1'b0;
      pass_q <= 1'b0;
    end else if (!en_i) begin
      fcnt_q <= '0;
      err_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_n;
      err_q  <= err_n;
      pass_q <= pass_n;
    end
  end

  assign pass_o = pass_q;
  assign err_o  = err_q;
endmodule

// File: rtl/vtpg_bist.sv
`timescale 1ns/1ps
module vtpg_bist
  import vtpg_pkg::*;
#(
  parameter int SMP_N43  = 64,
  parameter int SMP_N169 = 80,
  parameter int SMP_P43  = 72,
  parameter int SMP_P169 = 96,
  parameter int LINES_N  = 10,
  parameter int LINES_P  = 12,
  parameter int BLANK    = 16,
  parameter int VBL      = 1,
  parameter int LAT      = 3,
  localparam int SMP_MAXA = (SMP_N43 > SMP_N169) ? SMP_N43 : SMP_N169,
  localparam int SMP_MAXB = (SMP_P43 > SMP_P169) ? SMP_P43 : SMP_P169,
  localparam int SMP_MAX  = (SMP_MAXA > SMP_MAXB) ? SMP_MAXA : SMP_MAXB,
  localparam int SW = $clog2(SMP_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tpg_en_i,
  input  logic [WORD_W-1:0] code_i,
  input  logic [1:0]        fmt_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  output logic              pass_o
);
  logic run_q, pal_q, wide_q, tx_fend_q, chk_err;
  pat_e pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pat_q  <= PAT_NONE;
      pal_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      run_q <= tpg_en_i;
      if (tpg_en_i && !run_q) begin
        pat_q  <= code_to_pat(code_i);
        pal_q  <= fmt_i[0];
        wide_q <= fmt_i[1];
      end
    end
  end

  logic [SW-1:0] smp_w;
  logic          fld_w, vbl_w, upper_w, fend_w;
  logic [2:0]    bar_w;
  word_t         word_w;

  vtpg_raster #(
    .SMP_N43(SMP_N43), .SMP_N169(SMP_N169), .SMP_P43(SMP_P43), .SMP_P169(SMP_P169),
    .LINES_N(LINES_N), .LINES_P(LINES_P), .BLANK(BLANK), .VBL(VBL)
  ) i_raster (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .pal_i(pal_q), .wide_i(wide_q),
    .smp_o(smp_w), .fld_o(fld_w), .vbl_o(vbl_w), .upper_o(upper_w),
    .bar_o(bar_w), .fend_o(fend_w)
  );

  vtpg_pattern #(.BLANK(BLANK), .SW(SW)) i_pattern (
    .pat_i(pat_q), .smp_i(smp_w), .fld_i(fld_w), .vbl_i(vbl_w),
    .upper_i(upper_w), .bar_i(bar_w), .word_o(word_w)
  );

  logic live_w;
  assign live_w = tpg_en_i && run_q && (pat_q != PAT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o  <= '0;
      tx_valid_o <= 1'b0;
      tx_fend_q  <= 1'b0;
    end else begin
      tx_word_o  <= live_w ? word_w : '0;
      tx_valid_o <= live_w;
      tx_fend_q  <= live_w && fend_w;
    end
  end

  vtpg_checker #(.LAT(LAT)) i_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tpg_en_i),
    .tx_word_i(tx_word_o), .tx_valid_i(tx_valid_o), .tx_fend_i(tx_fend_q),
    .rx_word_i(rx_word_i), .pass_o(pass_o), .err_o(chk_err)
  );
endmodule

// File: rtl/vtpg_bist_sva.sv
`timescale 1ns/1ps
module vtpg_bist_sva
  import vtpg_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  tpg_en_i,
  input word_t tx_word_o,
  input logic  tx_valid_o,
  input logic  pass_o,
  input logic  err_q,
  input pat_e  pat_q
);
  assert_stop_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tpg_en_i |=> (!pass_o && !tx_valid_o));

  assert_start_on_eav_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_word_o == 10'h3FF));

  assert_trs_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_word_o == 10'h3FF) |=> (tx_word_o == 10'h000));

  assert_fail_holds_pass_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !pass_o);

  assert_legal_code_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (pat_q != PAT_NONE));
endmodule

bind vtpg_bist vtpg_bist_sva i_vtpg_bist_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .tpg_en_i(tpg_en_i), .tx_word_o(tx_word_o),
  .tx_valid_o(tx_valid_o), .pass_o(pass_o), .err_q(chk_err), .pat_q(pat_q)
);

// File: tb/test_vtpg_bist.sv
`timescale 1ns/1ps
module test_vtpg_bist;
  localparam int N43 = 64, N169 = 80, P43 = 72, P169 = 96;
  localparam int LN = 10, LP = 12, BLK = 16, VB = 1, LAT = 3;
  localparam logic [9:0] TY [8]  = '{10'h2D0, 10'h288, 10'h20C, 10'h1C0, 10'h150, 10'h104, 10'h08C, 10'h040};
  localparam logic [9:0] TCB [8] = '{10'h200, 10'h0B0, 10'h270, 10'h120, 10'h2E0, 10'h190, 10'h350, 10'h200};
  localparam logic [9:0] TCR [8] = '{10'h200, 10'h238, 10'h0B0, 10'h0E8, 10'h318, 10'h350, 10'h1C8, 10'h200};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [9:0] code = '0;
  logic [1:0] fmt = '0;
  logic       flip = 1'b0;
  logic [9:0] rx_word, tx_word;
  logic       tx_valid, pass;
  logic [9:0] lb [LAT];

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    lb[0] <= tx_word;
    for (int i = 1; i < LAT; i++) lb[i] <= lb[i-1];
  end
  assign rx_word = lb[LAT-1] ^ {9'b0, flip};

  vtpg_bist #(
    .SMP_N43(N43), .SMP_N169(N169), .SMP_P43(P43), .SMP_P169(P169),
    .LINES_N(LN), .LINES_P(LP), .BLANK(BLK), .VBL(VB), .LAT(LAT)
  ) i_vtpg_bist (
    .clk_i(clk), .rst_ni(rst_n), .tpg_en_i(en), .code_i(code), .fmt_i(fmt),
    .rx_word_i(rx_word), .tx_word_o(tx_word), .tx_valid_o(tx_valid), .pass_o(pass)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int tot_of(input bit pal, input bit wide);
    return pal ? (wide ? P169 : P43) : (wide ? N169 : N43);
  endfunction

  function automatic int lines_of(input bit pal);
    return pal ? LP : LN;
  endfunction

  // cls: 0 timing word, 1 blanking, 2 active
  function automatic logic [9:0] exp_word(input int cd, input bit pal, input bit wide,
                                          input int k, output int cls);
    int tot = tot_of(pal, wide);
    int lines = lines_of(pal);
    int half = lines / 2;
    int smp = k % tot;
    int ln = (k / tot) % lines;
    bit f = (ln >= half);
    int lif = f ? ln - half : ln;
    bit v = (lif < VB);
    bit h = (smp < 4);
    int a, s, b;
    if (smp < 4 || (smp >= BLK - 4 && smp < BLK)) begin
      cls = 0;
      case (smp % 4)
        0: return 10'h3FF;
        1, 2: return 10'h000;
        default: return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
      endcase
    end
    if (smp < BLK || v) begin
      cls = 1;
      return (smp % 2 == 1) ? 10'h040 : 10'h200;
    end
    cls = 2;
    a = smp - BLK;
    s = a % 4;
    case (cd)
      2: return (s % 2 == 1) ? 10'h110 : 10'h200;
      3: if (lif < half / 2) return (s % 2 == 1) ? 10'h198 : 10'h300;
         else return (s % 2 == 1) ? 10'h110 : 10'h200;
      4: begin
        b = a / ((tot - BLK) / 8);
        return (s % 2 == 1) ? TY[b] : ((s == 0) ? TCB[b] : TCR[b]);
      end
      default: return (s % 2 == 1) ? 10'h040 : 10'h200;
    endcase
  endfunction

  task automatic run_case(input logic [9:0] cw, input bit pal, input bit wide,
                          input int flip_at, input int extra);
    int tot = tot_of(pal, wide);
    int fw = (lines_of(pal) / 2) * tot;
    bit legal = (cw[9:4] == 0) && (cw[3:0] >= 1) && (cw[3:0] <= 4);
    int cd = int'(cw[3:0]);
    int last = 2 * fw + LAT + 2 + extra;
    int m_trs = 0, m_blk = 0, m_act = 0, m_vld = 0, m_pass = 0;
    int cls;
    logic [9:0] e;
    bit ep;
    @(negedge clk);
    code = cw; fmt = {wide, pal}; en = 1'b1; flip = 1'b0;
    for (int n = 0; n <= last; n++) begin
      @(negedge clk);
      if (tx_valid !== (legal && n >= 1)) m_vld++;
      if (legal && n >= 1) begin
        e = exp_word(cd, pal, wide, n - 1, cls);
        if (tx_word !== e) begin
          if (cls == 0) m_trs++;
          else if (cls == 1) m_blk++;
          else m_act++;
        end
      end
      ep = legal && (n >= 2 * fw + LAT + 1) && !(flip_at >= 0 && n >= flip_at + 1);
      if (pass !== ep) m_pass++;
      if (n == 3) begin
        code = 10'($urandom);   // R2: ignored while running
        fmt = 2'($urandom);
      end
      flip = (n == flip_at);
    end
    flip = 1'b0;
    en = 1'b0;
    @(negedge clk);
    chk(m_vld == 0, legal ? "R2 valid window" : "R7 illegal code stays idle", m_vld, 0);
    if (legal) begin
      chk(m_trs == 0, "R3 timing words", m_trs, 0);
      chk(m_blk == 0, "R4 blanking words", m_blk, 0);
      chk(m_act == 0, (cd == 4) ? "R6 bar words" : "R5 active words", m_act, 0);
    end
    chk(m_pass == 0, (flip_at >= 0) ? "R9 pass after mismatch" :
                     (legal ? "R8 pass timing" : "R7 pass low"), m_pass, 0);
    chk(pass == 1'b0 && tx_valid == 1'b0, "R10 stop clears outputs",
        int'({pass, tx_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(tx_valid == 0 && tx_word == 0 && pass == 0, "R1 reset idle",
        int'({tx_valid, pass, tx_word}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(10'h001, 1'b0, 1'b0, -1, 4);                            // R5 black
    run_case(10'h002, 1'b0, 1'b1, -1, 4);                            // R5 PLL
    run_case(10'h003, 1'b1, 1'b1, -1, 4);                            // R5 EQ
    run_case(10'h004, 1'b1, 1'b0, -1, 4);                            // R6 bars
    // R9: corrupt return of the last word of field two, same cycle as field count
    run_case(10'h004, 1'b0, 1'b0, 2 * (LN / 2) * N43 + LAT, 6);
    // R9: mismatch after pass already high
    run_case(10'h001, 1'b1, 1'b1, 2 * (LP / 2) * P169 + LAT + 4, 10);
    // R10: clean rerun after a failure
    run_case(10'h002, 1'b0, 1'b0, -1, 2);
    // R7: illegal codes
    run_case(10'h011, 1'b0, 1'b0, -1, 2);
    run_case(10'h007, 1'b1, 1'b0, -1, 2);

    for (int r = 0; r < 8; r++) begin
      logic [9:0] cw = 10'(1 + ($urandom % 4));
      bit p = 1'($urandom);
      bit w = 1'($urandom);
      int fw2 = 2 * (lines_of(p) / 2) * tot_of(p, w);
      int fa = ($urandom % 2 == 0) ? -1 : (LAT + 1 + int'($urandom % (fw2 + 4)));
      run_case(cw, p, w, fa, 6);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule